// File: doc/BRIEF.md
# Synchronous Byte Shifter with Octal Bit Counter

This block moves one byte at a time over a three-wire synchronous serial link. Transmit and receive run together: one bit leaves on the data output while one bit arrives on the data input. The link clock comes from one of three places: the clock pin driven by a partner device, a divided tick supplied by a prescaler outside the block, or the system clock. When the clock is generated internally, the block drives the clock pin.

Software loads the outgoing byte as two 4-bit nibbles, sets the mode, and then issues a start pulse. A 3-bit bit counter ends the transfer after eight clocks and raises an interrupt flag. The received byte can then be read as two nibbles through the same shift register. A mode write at any moment aborts the transfer and puts the block back into the wait-for-start state. The mode write also sets the level that the data output holds while idle.

In external-clock mode the block stays armed after a transfer completes. Any further clock edge sets the flag again. Software can therefore clear the flag and watch it, to learn whether a noise pulse on the clock line ended the transfer one clock early.

Top module: `serial_octet_shifter`

## Requirements
- R1: A transfer shifts exactly 8 bits, least significant bit first. The data output takes the next bit on each falling shift-clock edge. The data input is sampled on each rising edge and enters at bit 7 while the register shifts right. After the transfer, `rx_lo` holds bits 3:0 (the first four bits received) and `rx_hi` holds bits 7:4.
- R2: The clock source code `mode_src` is taken at a mode write. Code 00 selects the clock pin. Code 01 selects the `presc_tick` pulses. Codes 10 and 11 select every system clock. For codes other than 00, `sck_oe` is 1 and `sck_out` idles high. During a transfer `sck_out` toggles once per tick, and the first toggle is a fall.
- R3: Outside a transfer, and inside a transfer before its first falling edge, `sdo` equals the idle bit given at the last mode write (0 low, 1 high; 0 after reset). It returns to that level as soon as the eighth bit completes.
- R4: A mode write in any state, including mid-transfer, stops the transfer, clears the bit counter, drives `sck_out` high and enters the wait-for-start state. The next start then performs a full 8-bit transfer.
- R5: A start pulse in a wait state begins a transfer, and `busy` goes high on the next clock. A start pulse during a transfer has no effect.
- R6: On the eighth rising edge, `irq_flag` sets and `busy` drops.
- R7: `irq_clr` clears `irq_flag`. If a set event occurs in the same clock, the set wins.
- R8: The clock pin passes through a two-flop synchroniser. A pin level first sampled at clock edge k takes effect at edge k+2.
- R9: After a transfer completes in pin-clock mode, each further rising edge on the pin sets `irq_flag` until the next mode write or start. After a completion in an internal-clock mode, nothing sets the flag again.
- R10: Nibble writes (`wr_lo`, `wr_hi`) are ignored during a transfer and take effect in the wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe; reinitialises the shifter |
| mode_src | input | 2 | Clock source code captured on mode write |
| mode_idle_hi | input | 1 | Idle output level captured on mode write |
| start | input | 1 | Start-transfer strobe |
| wr_lo | input | 1 | Load low nibble of the shift register |
| wr_hi | input | 1 | Load high nibble of the shift register |
| wr_nib | input | 4 | Nibble data for loads |
| presc_tick | input | 1 | Divided clock tick from the external prescaler |
| sck_in | input | 1 | Clock pin input |
| sck_out | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Clock pin drive enable (internal source) |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| rx_lo | output | 4 | Shift register bits 3:0 |
| rx_hi | output | 4 | Shift register bits 7:4 |
| busy | output | 1 | Transfer in progress |
| irq_flag | output | 1 | Completion interrupt request flag |
| irq_clr | input | 1 | Clear strobe for the flag |

## Verification
If the bit counter drifts from the state machine, the completion flag rises on the wrong rising edge. A reference that tracks every clock therefore shows the error within one shift-clock period, and the received nibbles come out shifted. If the wait states and the transfer state are confused, the fault appears on `sdo` at once: the output leaves the idle level early or keeps the last bit after completion. It also appears on `sck_out`, which is not high while idle. A fault in the pin synchroniser moves every data change by whole cycles. This is checked by counting clocks from a pin fall to the first data-bit change. An armed state that fails to respond shows up only when a ninth pin pulse leaves the flag clear.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_XFER  = 2'd1,
    ST_ARMED = 2'd2
  } sh_state_e;

  localparam logic [1:0] SRC_PIN   = 2'b00;
  localparam logic [1:0] SRC_PRESC = 2'b01;
endpackage

// File: rtl/sck_edge_det.sv
module sck_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_sync
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[gi] <= 1'b1;
        else        sync_q[gi] <= pin;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[gi] <= 1'b1;
        else        sync_q[gi] <= sync_q[gi-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  // R8: a detected rise reflects the pin level STAGES edges earlier
  p_rise_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> ($past(pin, STAGES) && !$past(pin, STAGES + 1)));
endmodule

// File: rtl/shift_clk_gen.sv
module shift_clk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic sck,
  output logic fall_ev,
  output logic rise_ev
);
  assign fall_ev = run && tick && !restart && sck;
  assign rise_ev = run && tick && !restart && !sck;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       sck <= 1'b1;
    else if (restart) sck <= 1'b1;
    else if (fall_ev) sck <= 1'b0;
    else if (rise_ev) sck <= 1'b1;
endmodule

// File: rtl/octal_counter.sv
module octal_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = adv && !clear && (&cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (adv)   cnt <= cnt + 1'b1;

  // R6: the counter is back at zero after the eighth advance
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/serial_octet_shifter.sv
module serial_octet_shifter #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NIB_W      = DATA_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_src,
  input  logic             mode_idle_hi,
  input  logic             start,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [NIB_W-1:0] wr_nib,
  input  logic             presc_tick,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             sdi,
  output logic             sdo,
  output logic [NIB_W-1:0] rx_lo,
  output logic [NIB_W-1:0] rx_hi,
  output logic             busy,
  output logic             irq_flag,
  input  logic             irq_clr
);
  import sshift_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] shift_lsb_first(
    input logic [DATA_W-1:0] cur, input logic din);
    return {din, cur[DATA_W-1:1]};
  endfunction

  sh_state_e         state_q;
  logic [1:0]        src_q;
  logic              idle_q;
  logic [DATA_W-1:0] sh_q;
  logic              sdo_q;
  logic              irq_q;

  logic              use_pin, pin_rise, pin_fall;
  logic              gen_fall, gen_rise, gen_sck, tick_sel;
  logic              xfer_act, start_go, data_ok;
  logic              ev_fall, ev_rise, done_ev, armed_hit, flag_set;
  logic [CNT_W-1:0]  bit_cnt;

  assign use_pin   = (src_q == SRC_PIN);
  assign tick_sel  = (src_q == SRC_PRESC) ? presc_tick : 1'b1;
  assign xfer_act  = (state_q == ST_XFER) && !mode_wr;
  assign start_go  = start && !mode_wr && (state_q != ST_XFER);
  assign data_ok   = (state_q != ST_XFER);
  assign ev_fall   = xfer_act && (use_pin ? pin_fall : gen_fall);
  assign ev_rise   = xfer_act && (use_pin ? pin_rise : gen_rise);
  assign armed_hit = (state_q == ST_ARMED) && !mode_wr && !start_go && pin_rise;
  assign flag_set  = done_ev || armed_hit;

  sck_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(sck_in), .rise(pin_rise), .fall(pin_fall));

  shift_clk_gen u_gen (
    .clk(clk), .rst_n(rst_n),
    .run((state_q == ST_XFER) && !use_pin),
    .restart(mode_wr || start_go), .tick(tick_sel),
    .sck(gen_sck), .fall_ev(gen_fall), .rise_ev(gen_rise));

  octal_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(mode_wr || start_go),
    .adv(ev_rise), .cnt(bit_cnt), .wrap(done_ev));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= ST_WAIT;
      src_q   <= SRC_PIN;
      idle_q  <= 1'b0;
      sdo_q   <= 1'b0;
    end else if (mode_wr) begin
      state_q <= ST_WAIT;
      src_q   <= mode_src;
      idle_q  <= mode_idle_hi;
      sdo_q   <= mode_idle_hi;
    end else if (start_go) begin
      state_q <= ST_XFER;
    end else if (state_q == ST_XFER) begin
      if (ev_fall) sdo_q <= sh_q[0];
      if (done_ev) begin
        state_q <= use_pin ? ST_ARMED : ST_WAIT;
        sdo_q   <= idle_q;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh_q <= '0;
    else if (ev_rise) sh_q <= shift_lsb_first(sh_q, sdi);
    else begin
      if (data_ok && wr_lo) sh_q[NIB_W-1:0]      <= wr_nib;
      if (data_ok && wr_hi) sh_q[DATA_W-1:NIB_W] <= wr_nib;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        irq_q <= 1'b0;
    else if (flag_set) irq_q <= 1'b1;
    else if (irq_clr)  irq_q <= 1'b0;

  assign sck_out  = gen_sck;
  assign sck_oe   = !use_pin;
  assign sdo      = sdo_q;
  assign rx_lo    = sh_q[NIB_W-1:0];
  assign rx_hi    = sh_q[DATA_W-1:NIB_W];
  assign busy     = (state_q == ST_XFER);
  assign irq_flag = irq_q;

  // R3: idle output level outside a transfer
  p_idle_sdo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sdo == idle_q));
  // R2: generated clock rests high when no transfer runs
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);
  // R4: counter and state machine agree on idleness
  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bit_cnt == '0));
  // R4: mode write always leaves the transfer state
  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !busy);
  // R5: start from a wait state enters the transfer
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !mode_wr) |=> busy);
  // R6: completion sets the flag and ends the transfer
  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (irq_flag && !busy));
endmodule

// File: tb/test_serial_octet_shifter.sv
module test_serial_octet_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 0, mode_idle_hi = 0, start = 0, wr_lo = 0, wr_hi = 0;
  logic [1:0] mode_src = 0;
  logic [3:0] wr_nib = 0;
  logic       presc_tick = 0, sck_in = 1, sdi_ext = 0, sdi_int = 0, irq_clr = 0;
  logic       sdi, sck_out, sck_oe, sdo, busy, irq_flag;
  logic [3:0] rx_lo, rx_hi;

  int tests = 0, fails = 0, wd = 0;

  always #2 clk = ~clk;

  assign sdi = sck_oe ? sdi_int : sdi_ext;

  serial_octet_shifter i_serial_octet_shifter (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_src(mode_src),
    .mode_idle_hi(mode_idle_hi), .start(start), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_nib(wr_nib), .presc_tick(presc_tick), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .rx_lo(rx_lo), .rx_hi(rx_hi), .busy(busy), .irq_flag(irq_flag),
    .irq_clr(irq_clr));

  // ---------------- behavioural reference -----------------
  int       m_src = 0, m_state = 0, m_bits = 0;
  bit       m_idle = 0, m_sck = 1, m_sdo = 0, m_irq = 0;
  bit [7:0] m_reg = 0;
  bit       h1 = 1, h2 = 1, h3 = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_state = 0; m_bits = 0; m_idle = 0; m_sck = 1;
      m_sdo = 0; m_irq = 0; m_reg = 0; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      bit pr, pf, ext, tk, rs, fl, setf;
      int old_state;
      pr = h2 && !h3; pf = !h2 && h3;
      h3 = h2; h2 = h1; h1 = sck_in;
      ext = (m_src == 0);
      tk  = (m_src == 1) ? presc_tick : 1'b1;
      rs  = ext ? pr : (m_state == 1 && tk && !m_sck);
      fl  = ext ? pf : (m_state == 1 && tk && m_sck);
      setf = 0;
      old_state = m_state;
      if (mode_wr) begin
        m_state = 0; m_bits = 0; m_sck = 1;
        m_src = mode_src; m_idle = mode_idle_hi; m_sdo = mode_idle_hi;
      end else if (start && m_state != 1) begin
        m_state = 1; m_bits = 0; m_sck = 1;
      end else if (m_state == 1) begin
        if (fl) begin m_sdo = m_reg[0]; if (!ext) m_sck = 0; end
        if (rs) begin
          m_reg = {sdi, m_reg[7:1]};
          m_bits++;
          if (!ext) m_sck = 1;
          if (m_bits == 8) begin
            setf = 1; m_bits = 0; m_sdo = m_idle;
            m_state = ext ? 2 : 0;
          end
        end
      end else if (m_state == 2 && pr) setf = 1;
      if (old_state != 1 && !(m_state == 1 && rs)) begin
        if (wr_lo) m_reg[3:0] = wr_nib;
        if (wr_hi) m_reg[7:4] = wr_nib;
      end
      if (setf) m_irq = 1; else if (irq_clr) m_irq = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    tests++;
    if (sdo !== m_sdo) begin fails++; $display("FAIL R1 sdo act=%0b exp=%0b t=%0t", sdo, m_sdo, $time); end
    if (sck_out !== m_sck || sck_oe !== (m_src != 0)) begin fails++;
      $display("FAIL R2 sck act=%0b/%0b exp=%0b/%0b", sck_out, sck_oe, m_sck, m_src != 0); end
    if (busy !== (m_state == 1)) begin fails++; $display("FAIL R5 busy act=%0b exp=%0b", busy, m_state == 1); end
    if (irq_flag !== m_irq) begin fails++; $display("FAIL R6 irq act=%0b exp=%0b", irq_flag, m_irq); end
    if ({rx_hi, rx_lo} !== m_reg) begin fails++; $display("FAIL R1 rx act=%h exp=%h", {rx_hi, rx_lo}, m_reg); end
  end

  // prescaler tick: one pulse every third cycle
  int pdiv = 0;
  always @(negedge clk) begin pdiv = (pdiv + 1) % 3; presc_tick = (pdiv == 0); end

  // serial partner for internal clock modes
  bit       mon_prev = 1;
  int       mon_k = 0;
  bit [7:0] mon_pat = 0, tx_got = 0;
  always @(negedge clk) if (rst_n) begin
    if (!busy) mon_k = 0;
    else if (mon_prev && !sck_out && sck_oe && mon_k < 8) begin
      tx_got[mon_k] = sdo; sdi_int = mon_pat[mon_k]; mon_k++;
    end
    mon_prev = sck_out;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic mode(logic [1:0] s, logic idle);
    mode_wr = 1; mode_src = s; mode_idle_hi = idle; @(negedge clk); mode_wr = 0;
  endtask
  task automatic load(logic [7:0] b);
    wr_lo = 1; wr_nib = b[3:0]; @(negedge clk); wr_lo = 0;
    wr_hi = 1; wr_nib = b[7:4]; @(negedge clk); wr_hi = 0;
  endtask
  task automatic go(); start = 1; @(negedge clk); start = 0; endtask
  task automatic clr(); irq_clr = 1; @(negedge clk); irq_clr = 0; endtask
  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask
  task automatic pulse(logic d);
    sdi_ext = d; sck_in = 0; repeat (3) @(negedge clk);
    sck_in = 1; repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      fails++; $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R2 R3 R6)
    chk(sdo == 0 && sck_out == 1 && sck_oe == 0, "R3 reset sdo/sck", {sdo, sck_out, sck_oe}, 3'b010);
    chk(!busy && !irq_flag, "R6 reset flag", {busy, irq_flag}, 0);

    // system clock transfer (R1 R2 R6)
    mode(2'b10, 0); load(8'hA5); mon_pat = 8'h3C; go(); wait_idle(); @(negedge clk);
    chk({rx_hi, rx_lo} == 8'h3C, "R1 rx sysclk", {rx_hi, rx_lo}, 8'h3C);
    chk(tx_got == 8'hA5, "R1 tx sysclk", tx_got, 8'hA5);
    chk(irq_flag && !busy, "R6 done flag", {irq_flag, busy}, 2'b10);
    clr();
    chk(!irq_flag, "R7 flag cleared", irq_flag, 0);
    repeat (20) @(negedge clk);
    chk(!irq_flag, "R9 no re-set internal", irq_flag, 0);

    // set beats clear (R7)
    load(8'h11); mon_pat = 8'h00; go();
    for (int i = 0; i < 2000 && busy; i++) begin irq_clr = 1; @(negedge clk); end
    irq_clr = 0;
    chk(irq_flag, "R7 set wins", irq_flag, 1);
    clr();

    // prescaler clock, idle high, restart and writes ignored (R2 R3 R5 R10)
    mode(2'b01, 1);
    chk(sdo == 1, "R3 idle high", sdo, 1);
    load(8'h96); mon_pat = 8'hE1; go();
    start = 1; wr_lo = 1; wr_nib = 4'hF; @(negedge clk); start = 0; wr_lo = 0;
    chk(busy, "R5 start ignored busy", busy, 1);
    wait_idle(); @(negedge clk);
    chk(tx_got == 8'h96, "R10 tx unaffected", tx_got, 8'h96);
    chk({rx_hi, rx_lo} == 8'hE1, "R2 rx presc", {rx_hi, rx_lo}, 8'hE1);
    chk(sdo == 1, "R3 idle after done", sdo, 1);
    clr();

    // pin clock with latency check (R8 R1)
    mode(2'b00, 0); load(8'h01); go();
    sdi_ext = 1; sck_in = 0; @(negedge clk);
    chk(sdo == 0, "R8 edge+1", sdo, 0);
    @(negedge clk);
    chk(sdo == 0, "R8 edge+2 before", sdo, 0);
    @(negedge clk);
    chk(sdo == 1, "R8 edge+2 taken", sdo, 1);
    repeat (2) @(negedge clk); sck_in = 1; repeat (3) @(negedge clk);
    for (int i = 1; i < 8; i++) pulse(i[0]);
    repeat (4) @(negedge clk);
    chk({rx_hi, rx_lo} == 8'hAB, "R1 rx pin", {rx_hi, rx_lo}, 8'hAB);
    chk(irq_flag && !busy, "R6 pin done", {irq_flag, busy}, 2'b10);

    // spurious extra clock detection (R9)
    clr();
    chk(!irq_flag, "R7 clear pin", irq_flag, 0);
    pulse(0); @(negedge clk);
    chk(irq_flag, "R9 extra clock sets flag", irq_flag, 1);
    mode(2'b00, 0); clr(); pulse(0); @(negedge clk);
    chk(!irq_flag, "R9 disarmed by mode write", irq_flag, 0);

    // abort mid-transfer (R4)
    mode(2'b10, 0); load(8'hFF); mon_pat = 8'h00; go();
    repeat (5) @(negedge clk);
    mode(2'b10, 1);
    chk(!busy && sdo == 1 && sck_out == 1, "R4 abort", {busy, sdo, sck_out}, 3'b011);
    chk(!irq_flag, "R4 no flag on abort", irq_flag, 0);
    load(8'h0F); mon_pat = 8'h5A; go(); wait_idle(); @(negedge clk);
    chk(tx_got == 8'h0F, "R4 full tx after abort", tx_got, 8'h0F);
    chk({rx_hi, rx_lo} == 8'h5A, "R4 full rx after abort", {rx_hi, rx_lo}, 8'h5A);

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule